// File: doc/BRIEF.md
# Accumulator Shift and Logic Unit

This block is the accumulator execution stage of a small 16-bit controller core. Each cycle in which `issue` is high, it takes an already fetched instruction word, the present accumulator value, a second operand and the four incoming status flags (carry C, sign S, zero Z, overflow OV). It then produces the new accumulator and new flags in registers at the next clock edge. Operand fetch, register addressing and accumulator-pointer stepping belong to the surrounding core.

Two word families are recognised. The first is a fixed word `1000 1010 oooo 1010`, in which the nibble `oooo` (bits 7:4) picks an operation that needs only the accumulator. These are the complement, negation, shifts by one, two or four places, the rotates and the swaps. The second family has bits 11:8 equal to `1010` and a non-zero field in bits 14:12. It combines the accumulator with the operand using a logic or add/subtract operation.

Each operation rewrites only its own subset of flags. Every flag it does not name leaves the unit with the value it came in with. The core therefore feeds the registered flags back as the next inputs.

Top module: `acc_exec_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `acc_q`, `c_q`, `s_q`, `z_q`, `ov_q` and `upd_q` to 0.
- R2: The result of a word presented with `issue` high appears on the outputs at the next rising clock edge, and `upd_q` is 1 in that cycle. When `issue` is low, `upd_q` becomes 0 and the accumulator and flag outputs hold.
- R3: With the accumulator-only word, subcode 0001 gives the bitwise complement and subcode 1001 gives the two's-complement negation. Both write only S and Z.
- R4: Subcodes 0010, 0011 and 0110 shift left by 1, 2 and 4 places with zero fill. C receives the last bit shifted out of bit 15, and C, S and Z are written.
- R5: Subcodes 1111, 1110 and 1011 shift right by 1, 2 and 4 places, copying bit 15 into the vacated bits. C receives the last bit shifted out of bit 0, and only C and Z are written.
- R6: Subcode 1010 shifts right by one place with a 0 entering bit 15. C receives the old bit 0, and C, S and Z are written.
- R7: Subcode 0100 rotates left by one and subcode 1100 rotates right by one, without involving C. Only S is written.
- R8: Subcode 0101 rotates left through carry (C enters bit 0 and the old bit 15 goes to C). Subcode 1101 rotates right through carry (C enters bit 15 and the old bit 0 goes to C). C, S and Z are written.
- R9: Subcode 1000 exchanges the two bytes. Subcode 0111 exchanges the two nibbles inside each byte. Only S is written.
- R10: In the operand family (bits 11:8 = 1010; bit 15 and bits 7:0 are ignored), bits 14:12 equal to 001, 010 and 011 select AND, OR and XOR with the operand. Only S and Z are written.
- R11: Bits 14:12 equal to 100 select accumulator plus operand, and 110 selects accumulator plus operand plus C. C is the carry out of bit 15, OV is signed overflow, and C, S, Z and OV are all written.
- R12: Bits 14:12 equal to 101 select accumulator minus operand, and 111 selects accumulator minus operand minus C. C is 1 when a borrow occurs (the unsigned subtrahend, including C, exceeds the accumulator), OV is signed overflow, and all four flags are written.
- R13: When written, S equals bit 15 of the new accumulator and Z is 1 exactly when the new accumulator is zero. Each flag an operation does not write takes the value on its input.
- R14: Any other word can be issued. This covers subcode 0000, bits 14:12 of 000 outside the accumulator-only word, and bits 11:8 other than 1010. Such a word copies `acc_in` and all four incoming flags unchanged to the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Execute `instr` this cycle |
| instr | input | 16 | Instruction word |
| acc_in | input | 16 | Current accumulator |
| opnd_in | input | 16 | Second operand for the operand family |
| c_in | input | 1 | Incoming carry flag |
| s_in | input | 1 | Incoming sign flag |
| z_in | input | 1 | Incoming zero flag |
| ov_in | input | 1 | Incoming overflow flag |
| acc_q | output | 16 | New accumulator (registered) |
| c_q | output | 1 | New carry flag |
| s_q | output | 1 | New sign flag |
| z_q | output | 1 | New zero flag |
| ov_q | output | 1 | New overflow flag |
| upd_q | output | 1 | Result registered this cycle |

## Verification
The only state is the output register, so any decode or datapath fault shows on `acc_q` or a flag at the edge right after the issuing cycle. The fault stays visible until the next issue. Decode faults usually surface as a flag that should have passed through from its input but was rewritten, so the bench drives random incoming flags to expose them. Shift-count and carry-selection faults show as a wrong C or wrong vacated bits. The bench therefore concentrates on sign-bit patterns, zero results, overflow boundaries and both carry-in values.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [4:0] {
    OP_NONE, OP_CPL, OP_NEG,
    OP_SLA1, OP_SLA2, OP_SLA4,
    OP_RL, OP_RLC, OP_RR, OP_RRC,
    OP_SRA1, OP_SRA2, OP_SRA4, OP_SR,
    OP_XCH, OP_XCHN,
    OP_AND, OP_OR, OP_XOR,
    OP_ADD, OP_ADDC, OP_SUB, OP_SUBB
  } acc_op_e;

  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic ov;
  } acc_flags_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [15:0] instr,
  output acc_op_e     op,
  output acc_flags_t  wmask
);
  localparam logic [7:0] IMPL_HI  = 8'h8A;
  localparam logic [3:0] GRP_NIB  = 4'hA;

  logic is_impl, is_pair;

  assign is_impl = (instr[15:8] == IMPL_HI) && (instr[3:0] == GRP_NIB);
  assign is_pair = (instr[11:8] == GRP_NIB) && (instr[14:12] != 3'b000);

  always_comb begin
    op = OP_NONE;
    if (is_impl) begin
      case (instr[7:4])
        4'b0001: op = OP_CPL;
        4'b1001: op = OP_NEG;
        4'b0010: op = OP_SLA1;
        4'b0011: op = OP_SLA2;
        4'b0110: op = OP_SLA4;
        4'b0100: op = OP_RL;
        4'b0101: op = OP_RLC;
        4'b1111: op = OP_SRA1;
        4'b1110: op = OP_SRA2;
        4'b1011: op = OP_SRA4;
        4'b1010: op = OP_SR;
        4'b1100: op = OP_RR;
        4'b1101: op = OP_RRC;
        4'b1000: op = OP_XCH;
        4'b0111: op = OP_XCHN;
        default: op = OP_NONE;
      endcase
    end else if (is_pair) begin
      case (instr[14:12])
        3'b001:  op = OP_AND;
        3'b010:  op = OP_OR;
        3'b011:  op = OP_XOR;
        3'b100:  op = OP_ADD;
        3'b101:  op = OP_SUB;
        3'b110:  op = OP_ADDC;
        3'b111:  op = OP_SUBB;
        default: op = OP_NONE;
      endcase
    end
  end

  // write enables, field order {c, s, z, ov}
  always_comb begin
    case (op)
      OP_CPL, OP_NEG, OP_AND, OP_OR, OP_XOR:       wmask = 4'b0110;
      OP_SLA1, OP_SLA2, OP_SLA4, OP_SR,
      OP_RLC, OP_RRC:                              wmask = 4'b1110;
      OP_SRA1, OP_SRA2, OP_SRA4:                   wmask = 4'b1010;
      OP_RL, OP_RR, OP_XCH, OP_XCHN:               wmask = 4'b0100;
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB:            wmask = 4'b1111;
      default:                                     wmask = 4'b0000;
    endcase
  end
endmodule

// File: rtl/acc_unary.sv
module acc_unary
  import acc_pkg::*;
#(
  parameter int W = 16
) (
  input  acc_op_e        op,
  input  logic [W-1:0]   a,
  input  logic           c_in,
  output logic [W-1:0]   res,
  output logic           c_out
);
  localparam int NBYTES = W / 8;
  localparam int HALF   = W / 2;

  logic [W-1:0] nib_sw;
  logic [W-1:0] half_sw;

  for (genvar g = 0; g < NBYTES; g++) begin : g_nib
    assign nib_sw[8*g +: 8] = {a[8*g +: 4], a[8*g+4 +: 4]};
  end

  assign half_sw = {a[HALF-1:0], a[W-1:HALF]};

  always_comb begin
    res   = a;
    c_out = c_in;
    case (op)
      OP_CPL:  res = ~a;
      OP_NEG:  res = -a;
      OP_SLA1: begin res = a << 1; c_out = a[W-1]; end
      OP_SLA2: begin res = a << 2; c_out = a[W-2]; end
      OP_SLA4: begin res = a << 4; c_out = a[W-4]; end
      OP_SRA1: begin res = $signed(a) >>> 1; c_out = a[0]; end
      OP_SRA2: begin res = $signed(a) >>> 2; c_out = a[1]; end
      OP_SRA4: begin res = $signed(a) >>> 4; c_out = a[3]; end
      OP_SR:   begin res = a >> 1; c_out = a[0]; end
      OP_RL:   res = {a[W-2:0], a[W-1]};
      OP_RR:   res = {a[0], a[W-1:1]};
      OP_RLC:  begin res = {a[W-2:0], c_in}; c_out = a[W-1]; end
      OP_RRC:  begin res = {c_in, a[W-1:1]}; c_out = a[0]; end
      OP_XCH:  res = half_sw;
      OP_XCHN: res = nib_sw;
      default: begin res = a; c_out = c_in; end
    endcase
  end
endmodule

// File: rtl/acc_binary.sv
module acc_binary
  import acc_pkg::*;
#(
  parameter int W = 16
) (
  input  acc_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           c_in,
  output logic [W-1:0]   res,
  output logic           c_out,
  output logic           ov_out
);
  localparam int EW = W + 1;

  logic          is_sub;
  logic          cadd;
  logic [EW-1:0] ext;

  always_comb begin
    is_sub = (op == OP_SUB) || (op == OP_SUBB);
    cadd   = ((op == OP_ADDC) || (op == OP_SUBB)) ? c_in : 1'b0;
    if (is_sub)
      ext = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cadd};
    else
      ext = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cadd};
  end

  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = ext[W-1:0];
    endcase
    c_out = ext[W];
    if (is_sub)
      ov_out = (a[W-1] ^ b[W-1]) & (ext[W-1] ^ a[W-1]);
    else
      ov_out = ~(a[W-1] ^ b[W-1]) & (ext[W-1] ^ a[W-1]);
  end
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic [15:0]   instr,
  input  logic [W-1:0]  acc_in,
  input  logic [W-1:0]  opnd_in,
  input  logic          c_in,
  input  logic          s_in,
  input  logic          z_in,
  input  logic          ov_in,
  output logic [W-1:0]  acc_q,
  output logic          c_q,
  output logic          s_q,
  output logic          z_q,
  output logic          ov_q,
  output logic          upd_q
);
  acc_op_e      op;
  acc_flags_t   wmask;
  acc_flags_t   old_f, calc_f, next_f;
  logic [W-1:0] u_res, b_res, next_acc;
  logic         u_c, b_c, b_ov, pair_op;

  acc_decode i_dec (
    .instr (instr),
    .op    (op),
    .wmask (wmask)
  );

  acc_unary #(.W(W)) i_un (
    .op    (op),
    .a     (acc_in),
    .c_in  (c_in),
    .res   (u_res),
    .c_out (u_c)
  );

  acc_binary #(.W(W)) i_bin (
    .op     (op),
    .a      (acc_in),
    .b      (opnd_in),
    .c_in   (c_in),
    .res    (b_res),
    .c_out  (b_c),
    .ov_out (b_ov)
  );

  assign pair_op = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) ||
                   (op == OP_ADD) || (op == OP_ADDC) ||
                   (op == OP_SUB) || (op == OP_SUBB);

  always_comb begin
    old_f     = '{c: c_in, s: s_in, z: z_in, ov: ov_in};
    next_acc  = pair_op ? b_res : u_res;
    calc_f.c  = pair_op ? b_c : u_c;
    calc_f.s  = next_acc[W-1];
    calc_f.z  = (next_acc == '0);
    calc_f.ov = b_ov;
    next_f    = (calc_f & wmask) | (old_f & ~wmask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      c_q   <= 1'b0;
      s_q   <= 1'b0;
      z_q   <= 1'b0;
      ov_q  <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= issue;
      if (issue) begin
        acc_q <= next_acc;
        c_q   <= next_f.c;
        s_q   <= next_f.s;
        z_q   <= next_f.z;
        ov_q  <= next_f.ov;
      end
    end
  end
endmodule

// File: rtl/acc_exec_chk.sv
module acc_exec_chk #(
  parameter int W = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          issue,
  input logic [15:0]   instr,
  input logic [W-1:0]  acc_in,
  input logic [W-1:0]  opnd_in,
  input logic          c_in,
  input logic          s_in,
  input logic          z_in,
  input logic          ov_in,
  input logic [W-1:0]  acc_q,
  input logic          c_q,
  input logic          s_q,
  input logic          z_q,
  input logic          ov_q,
  input logic          upd_q
);
  a_r2_upd_after_issue: assert property (@(posedge clk) disable iff (rst)
    issue |=> upd_q);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !issue |=> !upd_q && $stable(acc_q) && $stable(c_q) && $stable(s_q) &&
               $stable(z_q) && $stable(ov_q));

  a_r5_sra_keeps_s_ov: assert property (@(posedge clk) disable iff (rst)
    issue && (instr == 16'h8AFA || instr == 16'h8AEA || instr == 16'h8ABA)
    |=> s_q == $past(s_in) && ov_q == $past(ov_in));

  a_r7_rot_keeps_czov: assert property (@(posedge clk) disable iff (rst)
    issue && (instr == 16'h8A4A || instr == 16'h8ACA)
    |=> c_q == $past(c_in) && z_q == $past(z_in) && ov_q == $past(ov_in));

  a_r10_logic_keeps_c_ov: assert property (@(posedge clk) disable iff (rst)
    issue && instr[11:8] == 4'hA && instr[14:12] != 3'b000 && instr[14] == 1'b0
    |=> c_q == $past(c_in) && ov_q == $past(ov_in));

  a_r11_add_sum: assert property (@(posedge clk) disable iff (rst)
    issue && instr[14:8] == 7'b100_1010
    |=> {c_q, acc_q} == ({1'b0, $past(acc_in)} + {1'b0, $past(opnd_in)}));

  a_r13_s_z_from_result: assert property (@(posedge clk) disable iff (rst)
    issue && instr[11:8] == 4'hA && instr[14:12] != 3'b000
    |=> s_q == acc_q[W-1] && z_q == (acc_q == '0));

  a_r14_zero_subcode_passes: assert property (@(posedge clk) disable iff (rst)
    issue && instr == 16'h8A0A
    |=> acc_q == $past(acc_in) && c_q == $past(c_in) && s_q == $past(s_in) &&
        z_q == $past(z_in) && ov_q == $past(ov_in));
endmodule

bind acc_exec_unit acc_exec_chk #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .issue(issue), .instr(instr),
  .acc_in(acc_in), .opnd_in(opnd_in),
  .c_in(c_in), .s_in(s_in), .z_in(z_in), .ov_in(ov_in),
  .acc_q(acc_q), .c_q(c_q), .s_q(s_q), .z_q(z_q), .ov_q(ov_q),
  .upd_q(upd_q)
);

// File: tb/test_acc_exec_unit.sv
module test_acc_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue = 1'b0;
  logic [15:0] instr = '0, acc_in = '0, opnd_in = '0;
  logic        c_in = 0, s_in = 0, z_in = 0, ov_in = 0;
  logic [15:0] acc_q;
  logic        c_q, s_q, z_q, ov_q, upd_q;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  acc_exec_unit i_acc_exec_unit (
    .clk(clk), .rst(rst), .issue(issue), .instr(instr),
    .acc_in(acc_in), .opnd_in(opnd_in),
    .c_in(c_in), .s_in(s_in), .z_in(z_in), .ov_in(ov_in),
    .acc_q(acc_q), .c_q(c_q), .s_q(s_q), .z_q(z_q), .ov_q(ov_q),
    .upd_q(upd_q)
  );

  // requirement tag for a word
  function automatic string tag_of(input logic [15:0] w);
    if (w[15:8] == 8'h8A && w[3:0] == 4'hA) begin
      case (w[7:4])
        4'h1, 4'h9:       return "R3";
        4'h2, 4'h3, 4'h6: return "R4";
        4'hF, 4'hE, 4'hB: return "R5";
        4'hA:             return "R6";
        4'h4, 4'hC:       return "R7";
        4'h5, 4'hD:       return "R8";
        4'h8, 4'h7:       return "R9";
        default:          return "R14";
      endcase
    end
    if (w[11:8] == 4'hA && w[14:12] != 0) begin
      if (w[14] == 1'b0) return "R10";
      if (w[12] == 1'b0) return "R11";
      return "R12";
    end
    return "R14";
  endfunction

  // expected {acc, c, s, z, ov}
  function automatic logic [19:0] model(input logic [15:0] w, a, b,
                                        input logic ci, si, zi, vi);
    logic [15:0] r;
    logic c, s, z, v, ws, wz;
    int k, ua, ub, sr, cc;
    r = a; c = ci; s = si; z = zi; v = vi; ws = 0; wz = 0; k = 0;
    ua = a; ub = b; cc = 0;
    if (w[15:8] == 8'h8A && w[3:0] == 4'hA) begin
      case (w[7:4])
        4'h1: begin r = ~a; ws = 1; wz = 1; end
        4'h9: begin r = 16'(32'h10000 - ua); ws = 1; wz = 1; end
        4'h2, 4'h3, 4'h6: begin
          k = (w[7:4] == 4'h2) ? 1 : (w[7:4] == 4'h3) ? 2 : 4;
          for (int i = 0; i < k; i++) begin c = r[15]; r = {r[14:0], 1'b0}; end
          ws = 1; wz = 1;
        end
        4'hF, 4'hE, 4'hB: begin
          k = (w[7:4] == 4'hF) ? 1 : (w[7:4] == 4'hE) ? 2 : 4;
          for (int i = 0; i < k; i++) begin c = r[0]; r = {r[15], r[15:1]}; end
          wz = 1;
        end
        4'hA: begin c = a[0]; r = {1'b0, a[15:1]}; ws = 1; wz = 1; end
        4'h4: begin r = {a[14:0], a[15]}; ws = 1; end
        4'hC: begin r = {a[0], a[15:1]}; ws = 1; end
        4'h5: begin c = a[15]; r = {a[14:0], ci}; ws = 1; wz = 1; end
        4'hD: begin c = a[0]; r = {ci, a[15:1]}; ws = 1; wz = 1; end
        4'h8: begin r = {a[7:0], a[15:8]}; ws = 1; end
        4'h7: begin r = {a[11:8], a[15:12], a[3:0], a[7:4]}; ws = 1; end
        default: ;
      endcase
    end else if (w[11:8] == 4'hA && w[14:12] != 0) begin
      ws = 1; wz = 1;
      if (w[14:12] == 3'd6 || w[14:12] == 3'd7) cc = int'(ci);
      case (w[14:12])
        3'd1: r = a & b;
        3'd2: r = a | b;
        3'd3: r = a ^ b;
        3'd4, 3'd6: begin
          r  = 16'(ua + ub + cc);
          c  = (ua + ub + cc) > 65535;
          sr = int'($signed(a)) + int'($signed(b)) + cc;
          v  = (sr > 32767) || (sr < -32768);
        end
        default: begin
          r  = 16'(ua - ub - cc);
          c  = ua < (ub + cc);
          sr = int'($signed(a)) - int'($signed(b)) - cc;
          v  = (sr > 32767) || (sr < -32768);
        end
      endcase
    end
    if (ws) s = r[15];
    if (wz) z = (r == 16'h0);
    return {r, c, s, z, v};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [19:0] got, input logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] w, a, b, input logic [3:0] f);
    logic [19:0] exp;
    string tg;
    @(negedge clk);
    instr = w; acc_in = a; opnd_in = b;
    {c_in, s_in, z_in, ov_in} = f;
    issue = 1'b1;
    exp = model(w, a, b, f[3], f[2], f[1], f[0]);
    tg = tag_of(w);
    @(negedge clk);
    issue = 1'b0;
    check(tg, "acc/flags", {acc_q, c_q, s_q, z_q, ov_q}, exp);
    check("R2", "upd after issue", {19'h0, upd_q}, 20'h1);
  endtask

  logic [15:0] impl_codes [15] = '{16'h8A1A, 16'h8A9A, 16'h8A2A, 16'h8A3A,
    16'h8A6A, 16'h8A4A, 16'h8A5A, 16'h8AFA, 16'h8AEA, 16'h8ABA, 16'h8AAA,
    16'h8ACA, 16'h8ADA, 16'h8A8A, 16'h8A7A};

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [19:0] held;
    logic [15:0] w;
    int pick;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reset", {acc_q, c_q, s_q, z_q, ov_q}, 20'h0);
    check("R1", "reset upd", {19'h0, upd_q}, 20'h0);
    rst = 1'b0;

    // directed corners
    run_op(16'h8A9A, 16'h8000, 16'h0, 4'b0000);   // R3 negate of most negative
    run_op(16'h8A9A, 16'h0000, 16'h0, 4'b1001);   // R3 negate of zero, C/OV kept
    run_op(16'h8A1A, 16'hFFFF, 16'h0, 4'b1111);   // R3 complement to zero
    run_op(16'h8A6A, 16'h1000, 16'h0, 4'b0001);   // R4 SLA4 last bit out
    run_op(16'h8A3A, 16'h4001, 16'h0, 4'b0000);   // R4 SLA2
    run_op(16'h8ABA, 16'h8008, 16'h0, 4'b0100);   // R5 SRA4 sign fill, S kept
    run_op(16'h8AFA, 16'h0001, 16'h0, 4'b0000);   // R5 SRA1 to zero
    run_op(16'h8AAA, 16'h8001, 16'h0, 4'b0000);   // R6 zero fill
    run_op(16'h8A4A, 16'h8000, 16'h0, 4'b1011);   // R7 RL keeps C,Z,OV
    run_op(16'h8ACA, 16'h0001, 16'h0, 4'b0010);   // R7 RR
    run_op(16'h8A5A, 16'h8000, 16'h0, 4'b0000);   // R8 RLC zero result
    run_op(16'h8ADA, 16'h0000, 16'h0, 4'b1000);   // R8 RRC carry into bit 15
    run_op(16'h8A8A, 16'h12F4, 16'h0, 4'b0000);   // R9 byte swap
    run_op(16'h8A7A, 16'h12F4, 16'h0, 4'b0000);   // R9 nibble swap
    run_op(16'h1A00, 16'hF0F0, 16'h0F0F, 4'b1001);// R10 AND zero, C/OV kept
    run_op(16'hAA55, 16'h8000, 16'h0001, 4'b0000);// R10 OR, bit 15 ignored
    run_op(16'h4A00, 16'h7FFF, 16'h0001, 4'b0000);// R11 overflow
    run_op(16'h6A00, 16'hFFFF, 16'h0000, 4'b1000);// R11 ADDC carry to zero
    run_op(16'h5A00, 16'h0000, 16'h0001, 4'b0000);// R12 borrow
    run_op(16'h7A00, 16'h0005, 16'h0005, 4'b1000);// R12 SUBB borrow via C
    run_op(16'hDA00, 16'h8000, 16'h0001, 4'b0000);// R12 signed overflow
    run_op(16'h8A0A, 16'hBEEF, 16'h1234, 4'b1010);// R14 subcode 0000
    run_op(16'h0A5A, 16'hBEEF, 16'h1234, 4'b0101);// R14 field 000
    run_op(16'h4B00, 16'h1111, 16'h2222, 4'b0110);// R14 bits 11:8 not 1010

    // R2: idle cycles hold outputs
    @(negedge clk);
    held = {acc_q, c_q, s_q, z_q, ov_q};
    instr = 16'h4A00; acc_in = 16'h7777; opnd_in = 16'h1; {c_in, s_in, z_in, ov_in} = 4'hF;
    @(negedge clk);
    check("R2", "idle hold", {acc_q, c_q, s_q, z_q, ov_q}, held);
    check("R2", "idle upd", {19'h0, upd_q}, 20'h0);

    // random mix (R13 covered by every flag comparison)
    for (int n = 0; n < 600; n++) begin
      pick = $urandom_range(0, 9);
      if (pick < 5) w = impl_codes[$urandom_range(0, 14)];
      else if (pick < 9) w = {1'($urandom), 3'($urandom_range(1, 7)), 4'hA, 8'($urandom)};
      else w = 16'($urandom);
      run_op(w, 16'($urandom), 16'($urandom), 4'($urandom));
    end

    // R1: reset mid-run clears
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "reset again", {acc_q, c_q, s_q, z_q, ov_q}, 20'h0);
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule